// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends characters over a single asynchronous serial line. A host writes a character into a one-entry holding register. As soon as the shift stage is free, the character moves there on its own. The shift stage sends it least significant bit first, between a low start bit and a high stop bit. Because the holding register empties at that move, the host can queue the next character while the current one is still going out. A character carries eight data bits, or nine when the nine-bit mode is on. In nine-bit mode the extra bit comes from a separate write input, so it can serve as an address marker or a parity bit.

Bit timing comes from an external one-cycle `baud_tick` strobe, and each tick ends the bit on the line. The block can also send a break on request: a start bit, twelve more low bit-times, then one stop bit. The request shows as pending until the stop bit of the break has gone out. An inversion control flips the line level, including the idle level. The block sends only while both the port enable and the transmit enable are high. Lowering either one aborts the character in progress and discards queued work.

Top module: `sertx_top`

## Requirements
- R1: Out of reset `hold_empty` is 1, `shift_empty` is 1, `brk_pending` is 0 and `tx_line` is 1 (with `invert` low).
- R2: A `wr_valid` strobe is accepted only while the block is active (`port_en` and `tx_en` both 1) and `hold_empty` is 1. `hold_empty` reads 0 from the next cycle. A write made while the holding register is full, or while the block is inactive, is dropped.
- R3: When the shift stage is empty and the holding register is full, the next clock edge loads the character. From that edge `hold_empty` is 1, `shift_empty` is 0 and the line carries the start bit (logical 0).
- R4: A data frame is the logical sequence 0 (start), the data bits least significant first, then 1 (stop). Each bit holds until a `baud_tick` ends it. A tick in the same cycle as the load is ignored.
- R5: `shift_empty` returns to 1 at the clock edge where the tick ends the stop bit.
- R6: `tx_line` equals the logical level XOR `invert`. This includes idle, where the logical level is 1.
- R7: A `brk_req` pulse while active sets `brk_pending`. When the shift stage is free, a pending break goes before a held character. The break is logical 0 for 13 bit-times (start plus 12), then one bit-time of 1. `brk_pending` clears at the edge that ends that final bit.
- R8: While the block is inactive the line idles at once. From the next edge `hold_empty` is 1, `shift_empty` is 1 and `brk_pending` is 0. A `brk_req` made while inactive has no effect.
- R9: With `nine_bit` at 1 when the character loads, nine data bits go out and `wr_bit8` is the ninth, sent just before the stop bit. With `nine_bit` at 0 only `wr_data` goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable |
| nine_bit | input | 1 | 1 selects nine data bits per character |
| invert | input | 1 | 1 inverts the line level |
| baud_tick | input | 1 | One-cycle strobe ending each bit-time |
| wr_valid | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Low eight data bits of the written character |
| wr_bit8 | input | 1 | Ninth data bit of the written character |
| brk_req | input | 1 | Request to send a break |
| hold_empty | output | 1 | Holding register is free for a write |
| shift_empty | output | 1 | No frame in progress |
| brk_pending | output | 1 | Break requested and not yet complete |
| tx_line | output | 1 | Serial output line |

## Verification
The assertions watch several rules on every cycle. They check that the line sits at idle whenever no frame is running. They check that a bit never changes between ticks. They check that a full holding register ignores writes while the shift stage is busy, and that a load empties the holding register and drives a start bit. They also check that disabling flushes everything, and that a held character waits behind a pending break. The bench's scenarios cover what needs a whole frame to judge. It decodes complete frames from the line at each tick and compares them with the written characters in order, in both widths and both polarities. It measures the break at 13 low bit-times. It confirms that an aborted frame and the writes dropped while the register was full or the block was off never appear on the line.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W  = 8;
  localparam int BRK_LOW = 12;
  localparam int FRAME_W = BRK_LOW + 2;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [LEN_W-1:0]   len_t;

  // Frame image sent LSB first: start 0, data bits, then ones (stop/idle).
  function automatic frame_t data_frame(input logic [DATA_W:0] d, input logic nine);
    frame_t f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i <= DATA_W; i++) begin
      if (i < DATA_W || nine) f[i+1] = d[i];
    end
    return f;
  endfunction

  function automatic len_t data_len(input logic nine);
    return len_t'(DATA_W + 2 + int'(nine));
  endfunction

  // Break: start plus BRK_LOW low bit-times, then a single stop bit.
  function automatic frame_t break_frame();
    frame_t f;
    f = '0;
    f[FRAME_W-1] = 1'b1;
    return f;
  endfunction

  function automatic len_t break_len();
    return len_t'(FRAME_W);
  endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_valid,
  input  logic [DATA_W:0]   wr_word,
  input  logic              take,
  output logic              full,
  output logic [DATA_W:0]   word,
  output logic              accept
);
  assign accept = active && wr_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (!active) begin
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b0;
    end else if (accept) begin
      full <= 1'b1;
      word <= wr_word;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   active,
  input  logic   tick,
  input  logic   load,
  input  frame_t load_frame,
  input  len_t   load_len,
  output logic   busy,
  output logic   line_bit,
  output logic   done
);
  frame_t sh;
  len_t   cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
    end else if (!active) begin
      sh  <= '1;
      cnt <= '0;
    end else if (load) begin
      sh  <= load_frame;
      cnt <= load_len;
    end else if (tick && busy) begin
      sh  <= {1'b1, sh[FRAME_W-1:1]};
      cnt <= cnt - len_t'(1);
    end
  end

  assign busy     = (cnt != '0);
  assign line_bit = busy ? sh[0] : 1'b1;
  assign done     = active && !load && tick && (cnt == len_t'(1));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_en,
  input  logic        tx_en,
  input  logic        nine_bit,
  input  logic        invert,
  input  logic        baud_tick,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic        wr_bit8,
  input  logic        brk_req,
  output logic        hold_empty,
  output logic        shift_empty,
  output logic        brk_pending,
  output logic        tx_line
);
  logic            active;
  logic            hold_full;
  logic [DATA_W:0] hold_word;
  logic            wr_accept;
  logic            busy;
  logic            line_bit;
  logic            frame_done;
  logic            load_brk;
  logic            load_data;
  logic            load_evt;
  logic            cur_brk;
  frame_t          next_frame;
  len_t            next_len;

  assign active    = port_en && tx_en;
  assign load_brk  = active && !busy && brk_pending;
  assign load_data = active && !busy && hold_full && !brk_pending;
  assign load_evt  = load_brk || load_data;

  assign next_frame = load_brk ? break_frame() : data_frame(hold_word, nine_bit);
  assign next_len   = load_brk ? break_len()   : data_len(nine_bit);

  sertx_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .wr_valid (wr_valid),
    .wr_word  ({wr_bit8, wr_data}),
    .take     (load_data),
    .full     (hold_full),
    .word     (hold_word),
    .accept   (wr_accept)
  );

  sertx_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .tick       (baud_tick),
    .load       (load_evt),
    .load_frame (next_frame),
    .load_len   (next_len),
    .busy       (busy),
    .line_bit   (line_bit),
    .done       (frame_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_pending <= 1'b0;
      cur_brk     <= 1'b0;
    end else if (!active) begin
      brk_pending <= 1'b0;
      cur_brk     <= 1'b0;
    end else begin
      if (load_evt) cur_brk <= load_brk;
      if (frame_done && cur_brk) brk_pending <= 1'b0;
      else if (brk_req)          brk_pending <= 1'b1;
    end
  end

  assign hold_empty  = !hold_full;
  assign shift_empty = !busy;
  assign tx_line     = (active ? line_bit : 1'b1) ^ invert;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic tx_en,
  input logic invert,
  input logic baud_tick,
  input logic wr_valid,
  input logic hold_empty,
  input logic shift_empty,
  input logic brk_pending,
  input logic tx_line,
  input logic load_evt,
  input logic load_data_evt,
  input logic frame_done
);
  logic act;
  assign act = port_en && tx_en;

  p_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act && wr_valid && !hold_empty && !shift_empty |=> !hold_empty);

  p_load_empties_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_data_evt |=> hold_empty && !shift_empty);

  p_load_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!(port_en && tx_en) || tx_line == invert));

  p_bit_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act && !shift_empty && !baud_tick ##1 act && $stable(invert) |-> $stable(tx_line));

  p_done_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> shift_empty);

  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> tx_line == !invert);

  p_break_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act && brk_pending && shift_empty && !hold_empty |=> !hold_empty);

  p_break_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_pending) |-> shift_empty);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> hold_empty && shift_empty && !brk_pending);
endmodule

bind sertx_top sertx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .port_en       (port_en),
  .tx_en         (tx_en),
  .invert        (invert),
  .baud_tick     (baud_tick),
  .wr_valid      (wr_valid),
  .hold_empty    (hold_empty),
  .shift_empty   (shift_empty),
  .brk_pending   (brk_pending),
  .tx_line       (tx_line),
  .load_evt      (load_evt),
  .load_data_evt (load_data),
  .frame_done    (frame_done)
);

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
  localparam int CLK_P   = 10;
  localparam int TICK_N  = 4;
  localparam int N_RAND  = 120;

  logic clk = 0, rst_n = 0, port_en = 0, tx_en = 0, nine_bit = 0, invert = 0;
  logic baud_tick = 0, wr_valid = 0, wr_bit8 = 0, brk_req = 0;
  logic [7:0] wr_data = 0;
  logic hold_empty, shift_empty, brk_pending, tx_line;

  int n_chk = 0, n_fail = 0;
  bit tick_en = 0, mon_en = 0;
  int tcnt = 0;
  bit [9:0] exp_q[$];
  int dstate = 0, dcnt = 0, lows = 0;
  bit dn = 0;
  bit [8:0] dbits;
  bit post_stop = 0, post_brk = 0;

  always #(CLK_P/2) clk = ~clk;

  sertx_top dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en), .nine_bit(nine_bit),
    .invert(invert), .baud_tick(baud_tick), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_bit8(wr_bit8), .brk_req(brk_req), .hold_empty(hold_empty),
    .shift_empty(shift_empty), .brk_pending(brk_pending), .tx_line(tx_line)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [8:0] expect_bits(input bit [9:0] e);
    return e[9] ? e[8:0] : {1'b0, e[7:0]};
  endfunction

  // Tick generator.
  always @(negedge clk) begin
    if (tick_en) begin
      tcnt = tcnt + 1;
      baud_tick = (tcnt % TICK_N == 0);
    end else begin
      baud_tick = 0;
    end
  end

  // Line decoder: samples each bit just before the tick that ends it.
  always @(negedge clk) begin
    #1;
    if (post_stop) begin
      check(shift_empty == 1, "R5 shift_empty after stop", shift_empty, 1);
      post_stop = 0;
    end
    if (post_brk) begin
      check(brk_pending == 0, "R7 brk_pending cleared", brk_pending, 0);
      post_brk = 0;
    end
    if (mon_en && baud_tick) begin
      automatic bit v = tx_line ^ invert;
      case (dstate)
        0: if (!v) begin dstate = 1; dcnt = 0; dbits = 0; dn = nine_bit; end
        1: begin
          dbits[dcnt] = v;
          dcnt++;
          if (dcnt == (dn ? 9 : 8)) dstate = 2;
        end
        2: begin
          if (v) begin
            if (exp_q.size() == 0) begin
              check(0, "R4 unexpected frame", dbits, 0);
            end else begin
              automatic bit [9:0] e = exp_q.pop_front();
              check(dbits == expect_bits(e), dn ? "R9 nine-bit frame" : "R4 frame data",
                    dbits, expect_bits(e));
            end
            post_stop = 1;
            dstate = 0;
          end else if (dbits == 0) begin
            lows = (dn ? 9 : 8) + 2;
            dstate = 3;
          end else begin
            check(0, "R4 stop bit", 0, 1);
            dstate = 0;
          end
        end
        default: begin
          if (!v) lows++;
          else begin
            check(lows == 13, "R7 break low length", lows, 13);
            post_brk = 1;
            dstate = 0;
          end
        end
      endcase
    end
  end

  task automatic write_char(input bit [7:0] d, input bit b8);
    bit acc;
    @(negedge clk);
    acc = hold_empty && port_en && tx_en;
    wr_valid = 1; wr_data = d; wr_bit8 = b8;
    if (acc) exp_q.push_back({nine_bit, b8, d});
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_idle();
    while (!(hold_empty && shift_empty && dstate == 0 && exp_q.size() == 0 && !brk_pending))
      @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    #1;
    check(hold_empty == 1,  "R1 hold_empty", hold_empty, 1);
    check(shift_empty == 1, "R1 shift_empty", shift_empty, 1);
    check(brk_pending == 0, "R1 brk_pending", brk_pending, 0);
    check(tx_line == 1,     "R1 tx_line", tx_line, 1);
    @(negedge clk); rst_n = 1; port_en = 1; tx_en = 1;

    // R2/R3 directed, ticks stopped
    @(negedge clk);
    wr_valid = 1; wr_data = 8'hA5; wr_bit8 = 0; exp_q.push_back({1'b0, 1'b0, 8'hA5});
    @(negedge clk); wr_valid = 0; #1;
    check(hold_empty == 0,  "R2 write accepted", hold_empty, 0);
    check(shift_empty == 1, "R2 not yet loaded", shift_empty, 1);
    @(negedge clk); #1;
    check(hold_empty == 1,  "R3 hold freed on load", hold_empty, 1);
    check(shift_empty == 0, "R3 shift busy", shift_empty, 0);
    check(tx_line == 0,     "R3 start bit", tx_line, 0);
    write_char(8'h3C, 0);
    #1 check(hold_empty == 0, "R2 second write held", hold_empty, 0);
    write_char(8'hFF, 0);
    #1 check(hold_empty == 0, "R2 write while full dropped", hold_empty, 0);
    tick_en = 1; mon_en = 1;
    wait_idle();
    check(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

    // R9 nine-bit
    nine_bit = 1;
    write_char(8'h55, 1);
    write_char(8'h0F, 0);
    wait_idle();
    nine_bit = 0;

    // R6 inversion
    @(negedge clk); invert = 1; #1;
    check(tx_line == 0, "R6 inverted idle", tx_line, 0);
    write_char(8'h96, 0);
    wait_idle();

    // R7 break with a held character behind it
    @(negedge clk);
    brk_req = 1; wr_valid = 1; wr_data = 8'h42; wr_bit8 = 0;
    exp_q.push_back({1'b0, 1'b0, 8'h42});
    @(negedge clk); brk_req = 0; wr_valid = 0; #1;
    check(brk_pending == 1, "R7 break pending", brk_pending, 1);
    @(negedge clk); #1;
    check(hold_empty == 0, "R7 break goes first", hold_empty, 0);
    wait_idle();
    invert = 0;

    // R8 abort and inactive inputs
    mon_en = 0;
    write_char(8'h81, 0);
    exp_q.delete();
    repeat (10) @(negedge clk);
    tx_en = 0; brk_req = 1; wr_valid = 1; wr_data = 8'h11; #1;
    check(tx_line == 1, "R8 idle at once", tx_line, 1);
    @(negedge clk); brk_req = 0; wr_valid = 0; #1;
    check(hold_empty == 1,  "R8 hold flushed", hold_empty, 1);
    check(shift_empty == 1, "R8 frame aborted", shift_empty, 1);
    check(brk_pending == 0, "R8 break ignored", brk_pending, 0);
    @(negedge clk); tx_en = 1;
    repeat (3) @(negedge clk); #1;
    check(hold_empty == 1 && brk_pending == 0, "R8 nothing queued", {hold_empty, brk_pending}, 2);
    check(shift_empty == 1, "R8 no frame after enable", shift_empty, 1);
    dstate = 0; mon_en = 1;

    // Random traffic
    begin
      int sent = 0;
      while (sent < N_RAND) begin
        @(negedge clk);
        if (hold_empty && shift_empty && dstate == 0 && exp_q.size() == 0 && !brk_pending
            && $urandom % 4 == 0) begin
          nine_bit = $urandom % 2;
          invert   = $urandom % 2;
          if ($urandom % 6 == 0) begin
            brk_req = 1; @(negedge clk); brk_req = 0;
          end
        end else if (hold_empty && $urandom % 3 == 0) begin
          wr_valid = 1; wr_data = 8'($urandom); wr_bit8 = 1'($urandom);
          exp_q.push_back({nine_bit, wr_bit8, wr_data});
          sent++;
          @(negedge clk); wr_valid = 0;
        end
      end
    end
    wait_idle();
    check(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
    finish_run();
  end
endmodule